// File: doc/BRIEF.md
# Two-Slot Receive Frame Store

This block takes received Ethernet frames from a byte stream and stores them in one of two on-chip frame buffers of `BUF_BYTES` bytes each. Software hands a buffer to the hardware by writing "loaded" into that slot's state register. When a frame starts, the block picks slot 0 if it is loaded, otherwise slot 1, and drops the frame if neither is loaded. The stored image is an 8-byte preamble and delimiter, then the frame bytes, then zero padding up to the minimum frame size, then a 4-byte CRC-32 frame check sequence.

When the image is complete, the block writes its total length into the slot's count register and sets the slot state to "pending". A level interrupt stays high while either slot is pending. Software reads the image through a 32-bit buffer read port, then writes the state back to empty or loaded. The finishing phase (padding, check sequence, preamble) takes up to 66 cycles after the last byte. Frames that start in that window are not stored.

Top module: `rx_slot_buffer`

## Requirements
- R1: After reset, both state registers and both count registers read 0, and `rx_irq` and `can_rx` are low.
- R2: Register addresses are 0 = slot 0 state, 1 = slot 0 count, 2 = slot 1 state, 3 = slot 1 count. A write updates the register on the clock edge, and `reg_rdata` shows the addressed register combinationally. State codes are 0 = empty, 1 = loaded and 2 = pending. `can_rx` is high exactly when at least one state equals 1.
- R3: At a frame start, the frame goes to slot 0 if its state is 1, otherwise to slot 1 if its state is 1. If neither is 1, the frame is dropped and no register changes.
- R4: The buffer holds 0x55 in bytes 0 to 6 and 0xD5 in byte 7, and frame byte i sits at byte 8+i. `buf_addr` = {slot, word index}. Byte 4w+k appears in bits 8k+7:8k of `buf_rdata` one clock after `buf_addr` is presented.
- R5: A frame shorter than 60 bytes is followed by zero bytes up to 60 bytes.
- R6: The check sequence is appended right after the padded bytes, least-significant byte first. It is a CRC-32 over the padded bytes using the reflected polynomial 0xEDB88320, an initial value of all ones and a final inversion.
- R7: On completion, the count register becomes the padded length plus 12 and the state becomes 2. This happens only if the chosen slot's state is still 1.
- R8: A frame whose length plus 12 exceeds `BUF_BYTES` is discarded. The slot's state and count keep their values.
- R9: `rx_irq` is high exactly when either state equals 2. It follows a register write from the next clock cycle on.
- R10: A frame start that arrives while the previous frame is still being finished is ignored, together with the rest of that frame. Valid bytes outside a frame with `rx_first` low are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_first | input | 1 | Byte is the first of a frame |
| rx_last | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Addressed register value |
| buf_addr | input | clog2(BUF_BYTES)-1 | Buffer word address {slot, word} |
| buf_rdata | output | 32 | Buffer word, one cycle latency |
| rx_irq | output | 1 | High while any slot is pending |
| can_rx | output | 1 | High while any slot is loaded |

## Verification
A wrong byte count or CRC register inside the block shows up only once the frame is finished, as a wrong count value or wrong check-sequence bytes. Those are visible at the register and buffer ports about 70 cycles after the last byte, so the bench checks every stored byte of each image. A wrong slot choice or a wrong ownership update shows in the state registers, `can_rx` and `rx_irq` within one cycle of completion. Frame lengths are chosen at the pad threshold, at the exact buffer limit and one byte beyond it, and a back-to-back start is sent inside the finishing window.

// File: rtl/rx_slot_buffer.sv
module rx_slot_buffer #(
  parameter int BUF_BYTES = 2048,
  parameter int MIN_FRAME = 60
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rx_valid,
  input  logic                          rx_first,
  input  logic                          rx_last,
  input  logic [7:0]                    rx_data,
  input  logic                          reg_wr,
  input  logic [1:0]                    reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic [$clog2(BUF_BYTES)-2:0]  buf_addr,
  output logic [31:0]                   buf_rdata,
  output logic                          rx_irq,
  output logic                          can_rx
);
  localparam int AW   = $clog2(BUF_BYTES);
  localparam int CW   = AW + 1;
  localparam int WW   = AW - 2;
  localparam int MAXF = BUF_BYTES - 12;

  typedef enum logic [2:0] {S_IDLE, S_RECV, S_PAD, S_FCS, S_PRE} st_t;

  st_t            st;
  logic           slot, ovf;
  logic [CW-1:0]  cnt;
  logic [1:0]     sub;
  logic [31:0]    crc;
  logic [1:0]     sstate [2];
  logic [CW-1:0]  scount [2];

  logic [31:0]    mem [2**(AW-1)];
  logic           we, sel, cur_slot, start_ok, fits;
  logic [3:0]     be;
  logic [31:0]    wd, crc_fin;
  logic [CW-1:0]  boff;
  logic [AW-2:0]  widx;
  logic           unused_wdata;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  assign can_rx    = (sstate[0] == 2'd1) || (sstate[1] == 2'd1);
  assign rx_irq    = (sstate[0] == 2'd2) || (sstate[1] == 2'd2);
  assign sel       = (sstate[0] != 2'd1);
  assign cur_slot  = (st == S_IDLE) ? sel : slot;
  assign start_ok  = (st == S_IDLE) && rx_valid && rx_first && can_rx;
  assign fits      = cnt < CW'(MAXF);
  assign crc_fin   = ~crc;
  assign reg_rdata = reg_addr[0] ? 32'(scount[reg_addr[1]]) : 32'(sstate[reg_addr[1]]);
  assign unused_wdata = ^reg_wdata[31:CW];

  always_comb begin
    we   = 1'b0;
    wd   = {4{rx_data}};
    boff = CW'(8) + cnt;
    case (st)
      S_IDLE: we = start_ok;
      S_RECV: we = rx_valid && fits;
      S_PAD: begin we = 1'b1; wd = '0; end
      S_FCS: begin
        we   = 1'b1;
        boff = CW'(8) + cnt + CW'(sub);
        wd   = {4{crc_fin[{sub, 3'b000} +: 8]}};
      end
      default: ;
    endcase
    be   = 4'b0001 << boff[1:0];
    widx = {cur_slot, boff[AW-1:2]};
    if (st == S_PRE) begin
      we   = 1'b1;
      be   = 4'hF;
      widx = {slot, WW'(sub[0])};
      wd   = sub[0] ? 32'hD5555555 : 32'h55555555;
    end
  end

  always_ff @(posedge clk) begin
    if (we)
      for (int k = 0; k < 4; k++)
        if (be[k]) mem[widx][8*k +: 8] <= wd[8*k +: 8];
    buf_rdata <= mem[buf_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      slot      <= 1'b0;
      ovf       <= 1'b0;
      cnt       <= '0;
      sub       <= '0;
      crc       <= '1;
      sstate[0] <= '0;
      sstate[1] <= '0;
      scount[0] <= '0;
      scount[1] <= '0;
    end else begin
      if (reg_wr) begin
        if (reg_addr[0]) scount[reg_addr[1]] <= reg_wdata[CW-1:0];
        else             sstate[reg_addr[1]] <= reg_wdata[1:0];
      end
      case (st)
        S_IDLE: begin
          ovf <= 1'b0;
          if (start_ok) begin
            slot <= sel;
            crc  <= crc_step('1, rx_data);
            cnt  <= CW'(1);
            st   <= !rx_last ? S_RECV : (CW'(1) < CW'(MIN_FRAME) ? S_PAD : S_FCS);
          end
        end
        S_RECV: if (rx_valid) begin
          if (fits) begin
            cnt <= cnt + CW'(1);
            crc <= crc_step(crc, rx_data);
          end else ovf <= 1'b1;
          if (rx_last) begin
            if (ovf || !fits) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else st <= (cnt + CW'(1) < CW'(MIN_FRAME)) ? S_PAD : S_FCS;
          end
        end
        S_PAD: begin
          cnt <= cnt + CW'(1);
          crc <= crc_step(crc, 8'h00);
          if (cnt + CW'(1) >= CW'(MIN_FRAME)) st <= S_FCS;
        end
        S_FCS: begin
          sub <= sub + 2'd1;
          if (sub == 2'd3) st <= S_PRE;
        end
        S_PRE: begin
          sub <= sub + 2'd1;
          if (sub[0]) begin
            st  <= S_IDLE;
            sub <= '0;
            cnt <= '0;
            if (sstate[slot] == 2'd1) begin
              scount[slot] <= cnt + CW'(12);
              sstate[slot] <= 2'd2;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rx_slot_buffer_chk #(
  parameter int CW        = 12,
  parameter int BUF_BYTES = 2048,
  parameter int MIN_FRAME = 60
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [2:0]    st,
  input logic          can_rx,
  input logic [1:0]    s0,
  input logic [1:0]    s1,
  input logic [CW-1:0] c0,
  input logic [CW-1:0] c1
);
  p_pend_from_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s0 == 2'd2 && $past(s0) != 2'd2 && !$past(reg_wr && reg_addr == 2'd0)) |-> $past(s0) == 2'd1);

  p_pend1_from_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1 == 2'd2 && $past(s1) != 2'd2 && !$past(reg_wr && reg_addr == 2'd2)) |-> $past(s1) == 2'd1);

  p_count_hw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c0 != $past(c0) && !$past(reg_wr && reg_addr == 2'd1)) |-> (s0 == 2'd2 && $past(s0) == 2'd1));

  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s0 == 2'd2 && $past(s0) == 2'd1 && !$past(reg_wr)) |-> (c0 >= CW'(MIN_FRAME + 12) && c0 <= CW'(BUF_BYTES)));

  p_one_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> !(s0 == 2'd2 && $past(s0) == 2'd1 && s1 == 2'd2 && $past(s1) == 2'd1));

  p_start_needs_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 3'd0 && st != 3'd0) |-> $past(can_rx));
endmodule

bind rx_slot_buffer rx_slot_buffer_chk #(.CW(CW), .BUF_BYTES(BUF_BYTES), .MIN_FRAME(MIN_FRAME)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .st(st), .can_rx(can_rx),
  .s0(sstate[0]), .s1(sstate[1]), .c0(scount[0]), .c1(scount[1])
);

// File: tb/rx_slot_buffer_tb_top.sv
module rx_slot_buffer_tb_top;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_first = 0, rx_last = 0;
  logic [7:0] rx_data = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, buf_rdata;
  logic [9:0] buf_addr = 0;
  logic rx_irq, can_rx;

  int total = 0, bad = 0;
  logic [7:0] frm [2048];
  logic [7:0] expb [2048];

  localparam int VEC [6][3] = '{'{1, 'h3A, 72}, '{59, 'h10, 72}, '{60, 'hC4, 72},
                                '{61, 'h01, 73}, '{64, 'h7F, 76}, '{300, 'h99, 312}};

  rx_slot_buffer dut_i (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed, input bit use_first);
    for (int i = 0; i < len; i++) begin
      frm[i] = seed + 8'(i * 13);
      @(negedge clk);
      rx_valid = 1; rx_first = use_first && (i == 0); rx_last = (i == len - 1); rx_data = frm[i];
    end
    @(negedge clk); rx_valid = 0; rx_first = 0; rx_last = 0;
  endtask

  function automatic logic [31:0] bcrc(input logic [31:0] c, input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[i];
      c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return c;
  endfunction

  task automatic check_buf(input logic slot, input int len, input string tag);
    int pl, tot, errs;
    logic [31:0] c, w;
    longint a_v, e_v;
    pl = (len < 60) ? 60 : len;
    tot = pl + 12;
    for (int k = 0; k < 7; k++) expb[k] = 8'h55;
    expb[7] = 8'hD5;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < pl; i++) begin
      expb[8 + i] = (i < len) ? frm[i] : 8'h00;
      c = bcrc(c, expb[8 + i]);
    end
    c = ~c;
    for (int j = 0; j < 4; j++) expb[8 + pl + j] = c[8*j +: 8];
    errs = 0; a_v = 0; e_v = 0;
    for (int wi = 0; wi < (tot + 3) / 4; wi++) begin
      @(negedge clk); buf_addr = {slot, 9'(wi)};
      @(negedge clk); w = buf_rdata;
      for (int k = 0; k < 4; k++)
        if (4 * wi + k < tot && w[8*k +: 8] !== expb[4*wi + k]) begin
          if (errs == 0) begin a_v = longint'(w[8*k +: 8]); e_v = longint'(expb[4*wi + k]); end
          errs++;
        end
    end
    chk(errs == 0, tag, a_v, e_v);
  endtask

  task automatic settle();
    repeat (100) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      chk(d == 0, "R1 register reset", d, 0);
    end
    chk(!rx_irq && !can_rx, "R1 irq/can_rx reset", {rx_irq, can_rx}, 0);

    send_frame(20, 8'h21, 1); settle();
    rd_reg(0, d); chk(d == 0, "R3 drop none loaded s0", d, 0);
    rd_reg(3, d); chk(d == 0, "R3 drop none loaded c1", d, 0);

    wr_reg(2, 1); rd_reg(2, d);
    chk(d == 1 && can_rx, "R2 state write/can_rx", {d[1:0], can_rx}, 3'b011);
    wr_reg(3, 5); rd_reg(3, d); chk(d == 5, "R2 count write", d, 5);
    wr_reg(2, 0); wr_reg(3, 0);
    chk(!can_rx, "R2 can_rx low", can_rx, 0);

    for (int v = 0; v < 6; v++) begin
      wr_reg(0, 1);
      send_frame(VEC[v][0], 8'(VEC[v][1]), 1); settle();
      rd_reg(0, d); chk(d == 2, "R7 state pending", d, 2);
      rd_reg(1, d); chk(d == 32'(VEC[v][2]), "R7 count", d, VEC[v][2]);
      chk(rx_irq, "R9 irq on pending", rx_irq, 1);
      check_buf(0, VEC[v][0], "R4 R5 R6 image");
      wr_reg(0, 0);
      chk(!rx_irq, "R9 irq clear on write", rx_irq, 0);
    end

    wr_reg(0, 1); wr_reg(2, 1);
    send_frame(70, 8'h05, 1); settle();
    rd_reg(0, d); chk(d == 2, "R3 slot0 first", d, 2);
    rd_reg(2, d); chk(d == 1, "R3 slot1 untouched", d, 1);
    chk(can_rx, "R2 can_rx one loaded", can_rx, 1);
    send_frame(80, 8'h66, 1); settle();
    rd_reg(2, d); chk(d == 2, "R3 slot1 used", d, 2);
    rd_reg(3, d); chk(d == 92, "R7 slot1 count", d, 92);
    check_buf(1, 80, "R4 slot1 image");
    chk(!can_rx && rx_irq, "R2 R9 both pending", {can_rx, rx_irq}, 2'b01);
    wr_reg(2, 0);
    chk(rx_irq, "R9 irq held by slot0", rx_irq, 1);
    wr_reg(0, 0);
    chk(!rx_irq, "R9 irq low", rx_irq, 0);

    wr_reg(0, 1); wr_reg(2, 1);
    send_frame(10, 8'h40, 1);
    send_frame(10, 8'h50, 1); settle();
    rd_reg(0, d); chk(d == 2, "R10 first frame stored", d, 2);
    rd_reg(2, d); chk(d == 1, "R10 second frame dropped", d, 1);
    wr_reg(0, 1); wr_reg(2, 0);
    send_frame(12, 8'h70, 0); settle();
    rd_reg(0, d); chk(d == 1, "R10 stray bytes ignored", d, 1);

    wr_reg(1, 7);
    send_frame(2037, 8'h0F, 1); settle();
    rd_reg(0, d); chk(d == 1, "R8 oversize state kept", d, 1);
    rd_reg(1, d); chk(d == 7, "R8 oversize count kept", d, 7);
    send_frame(2036, 8'hE1, 1); settle();
    rd_reg(0, d); chk(d == 2, "R8 limit frame accepted", d, 2);
    rd_reg(1, d); chk(d == 2048, "R8 limit count", d, 2048);
    check_buf(0, 2036, "R6 limit image");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule